// File: doc/BRIEF.md
# Sector Erase Acceptance Window Controller

This block sits inside a flash command interface, downstream of the command decoder. When a sector erase command arrives, it opens an acceptance window. While the window is open, more sector erase commands may be queued, and each one adds its sector to a selection bitmap and restarts the full window. Time is counted in ticks from a free-running microsecond strobe. When the window runs out with no new sector command, the block offers the accumulated bitmap to the erase engine and raises status bit 3.

From the moment status bit 3 is high until the erase engine reports completion, the block locks out commands. The combinational `cmd_drop` output tells the decoder to discard every command except erase suspend. A chip erase command skips the window entirely: it goes straight to the erase engine with every sector selected. When the engine reports completion, the bitmap clears and the block returns to idle.

The start request to the erase engine is a valid/ready output. `start_valid` and the data it carries (`sel_map`, `start_chip`) stay asserted and unchanged until `start_ready` is sampled high. The transfer takes place on the clock edge where both are high. The engine may hold `start_ready` low for as long as it needs. The lockout stays in force during that back-pressure.

Top module: `erase_window_ctrl`

## Requirements
- R1: After reset, `status_b3`, `cmd_drop` and `start_valid` are 0 and `sel_map` is all zeros.
- R2: A sector erase command (`cmd_op` = 1) accepted while idle sets bit `cmd_sector` of `sel_map` on the next cycle and opens the window. `status_b3` stays 0.
- R3: Each further sector erase command during the window ORs its sector bit into `sel_map`, and `status_b3` stays 0.
- R4: Each accepted sector erase command reloads the window. The start request appears after exactly `WIN_US` ticks following the last accepted sector command. A command in the same cycle as the final tick wins over the expiry.
- R5: When the window expires, `status_b3` becomes 1 and `start_valid` rises with `start_chip` = 0 and `sel_map` holding the selection.
- R6: While `start_valid` is high and `start_ready` is low, `start_valid` stays high and `sel_map` is unchanged. The request completes in the cycle where both are high.
- R7: While `status_b3` is 1, any valid command other than erase suspend drives `cmd_drop` high in the same cycle and changes neither `sel_map` nor the timer.
- R8: An erase suspend command (`cmd_op` = 3) is never dropped. `cmd_drop` is 0 for it.
- R9: A chip erase command (`cmd_op` = 2) accepted while idle raises `start_valid` on the next cycle, with `start_chip` = 1, `sel_map` all ones and `status_b3` = 1, and opens no window.
- R10: `erase_done` after the start request has been taken returns the block to idle: `status_b3` goes to 0 and `sel_map` clears. `erase_done` at any other time has no effect.
- R11: `us_tick` outside the window has no effect. During the window, chip erase and other commands (`cmd_op` = 0) leave `sel_map` and the timer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| us_tick | input | 1 | One-cycle microsecond strobe |
| cmd_valid | input | 1 | Decoded command strobe |
| cmd_op | input | 2 | 0 other, 1 sector erase, 2 chip erase, 3 erase suspend |
| cmd_sector | input | SECT_W | Sector index for sector erase |
| erase_done | input | 1 | Erase engine finished |
| start_ready | input | 1 | Erase engine accepts start request |
| status_b3 | output | 1 | Status bit 3: 1 once the window has closed |
| cmd_drop | output | 1 | Decoder must ignore the current command |
| sel_map | output | NSECT | Selected sector bitmap |
| start_valid | output | 1 | Start request to the erase engine |
| start_chip | output | 1 | Start request is a chip erase |

## Verification
The bench builds the block with `WIN_US` = 5 and the default eight sectors. The short window lets it count every tick up to expiry and confirm that nothing starts one tick early. With that window it can also place a sector command on the exact cycle of the final tick, and pile several reloads into one window, in a few hundred cycles. Eight sectors give an all-ones chip map and single-bit sector maps that tell the two erase paths apart at a glance.

// File: rtl/erw_pkg.sv
package erw_pkg;
  typedef enum logic [1:0] {
    OP_OTHER = 2'd0,
    OP_SECT  = 2'd1,
    OP_CHIP  = 2'd2,
    OP_SUSP  = 2'd3
  } erw_op_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WIN    = 2'd1,
    ST_LAUNCH = 2'd2,
    ST_BUSY   = 2'd3
  } erw_state_e;
endpackage

// File: rtl/erw_timer.sv
module erw_timer #(
  parameter int WIN_US = 50,
  localparam int CNT_W = $clog2(WIN_US + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  input  logic tick,
  output logic expire
);
  logic [CNT_W-1:0] cnt_q;

  // a reload in the same cycle as the final tick wins
  assign expire = run && tick && !load && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            cnt_q <= '0;
    else if (load)                         cnt_q <= CNT_W'(WIN_US);
    else if (run && tick && cnt_q != '0)   cnt_q <= cnt_q - CNT_W'(1);
  end
endmodule

// File: rtl/erw_map.sv
module erw_map #(
  parameter int NSECT = 8,
  localparam int SECT_W = (NSECT > 1) ? $clog2(NSECT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic [SECT_W-1:0] set_idx,
  input  logic              fill_all,
  input  logic              clear,
  output logic [NSECT-1:0]  map
);
  logic [NSECT-1:0] onehot;

  always_comb begin
    onehot = '0;
    for (int i = 0; i < NSECT; i++)
      if (set_idx == SECT_W'(i)) onehot[i] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        map <= '0;
    else if (clear)    map <= '0;
    else if (fill_all) map <= '1;
    else if (set_en)   map <= map | onehot;
  end
endmodule

// File: rtl/erw_fsm.sv
module erw_fsm
  import erw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sect_go,
  input  logic chip_go,
  input  logic expire,
  input  logic start_ready,
  input  logic erase_done,
  output logic idle,
  output logic in_window,
  output logic locked,
  output logic busy,
  output logic start_valid,
  output logic start_chip
);
  erw_state_e state_q, state_d;
  logic chip_q, chip_d;

  always_comb begin
    state_d = state_q;
    chip_d  = chip_q;
    unique case (state_q)
      ST_IDLE: begin
        if (chip_go) begin
          state_d = ST_LAUNCH;
          chip_d  = 1'b1;
        end else if (sect_go) begin
          state_d = ST_WIN;
        end
      end
      ST_WIN:    if (expire)      state_d = ST_LAUNCH;
      ST_LAUNCH: if (start_ready) state_d = ST_BUSY;
      ST_BUSY: begin
        if (erase_done) begin
          state_d = ST_IDLE;
          chip_d  = 1'b0;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      chip_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      chip_q  <= chip_d;
    end
  end

  assign idle        = (state_q == ST_IDLE);
  assign in_window   = (state_q == ST_WIN);
  assign start_valid = (state_q == ST_LAUNCH);
  assign busy        = (state_q == ST_BUSY);
  assign locked      = start_valid || busy;
  assign start_chip  = start_valid && chip_q;
endmodule

// File: rtl/erase_window_ctrl.sv
module erase_window_ctrl
  import erw_pkg::*;
#(
  parameter int NSECT  = 8,
  parameter int WIN_US = 50,
  localparam int SECT_W = (NSECT > 1) ? $clog2(NSECT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              us_tick,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [SECT_W-1:0] cmd_sector,
  input  logic              erase_done,
  input  logic              start_ready,
  output logic              status_b3,
  output logic              cmd_drop,
  output logic [NSECT-1:0]  sel_map,
  output logic              start_valid,
  output logic              start_chip
);
  erw_op_e op;
  logic idle, in_window, locked, busy, expire;
  logic sect_go, chip_go, done_go;

  assign op      = erw_op_e'(cmd_op);
  assign sect_go = cmd_valid && (op == OP_SECT) && (idle || in_window);
  assign chip_go = cmd_valid && (op == OP_CHIP) && idle;
  assign done_go = busy && erase_done;

  assign cmd_drop  = locked && cmd_valid && (op != OP_SUSP);
  assign status_b3 = locked;

  erw_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .sect_go     (sect_go),
    .chip_go     (chip_go),
    .expire      (expire),
    .start_ready (start_ready),
    .erase_done  (erase_done),
    .idle        (idle),
    .in_window   (in_window),
    .locked      (locked),
    .busy        (busy),
    .start_valid (start_valid),
    .start_chip  (start_chip)
  );

  erw_timer #(.WIN_US(WIN_US)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (sect_go),
    .run    (in_window),
    .tick   (us_tick),
    .expire (expire)
  );

  erw_map #(.NSECT(NSECT)) u_map (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_en   (sect_go),
    .set_idx  (cmd_sector),
    .fill_all (chip_go),
    .clear    (done_go),
    .map      (sel_map)
  );
endmodule

// File: rtl/erw_checker.sv
module erw_checker #(
  parameter int NSECT = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic [1:0]       cmd_op,
  input logic             erase_done,
  input logic             start_ready,
  input logic             status_b3,
  input logic             cmd_drop,
  input logic [NSECT-1:0] sel_map,
  input logic             start_valid,
  input logic             start_chip
);
  assert_start_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start_valid |-> status_b3);

  assert_hold_request_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start_valid && !start_ready) |=> (start_valid && $stable(sel_map) && $stable(start_chip)));

  assert_drop_in_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (status_b3 && cmd_valid && cmd_op != 2'd3) |-> cmd_drop);

  assert_suspend_passes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_drop |-> (status_b3 && cmd_valid && cmd_op != 2'd3));

  assert_map_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (status_b3 && !(erase_done && !start_valid)) |=> $stable(sel_map));

  assert_done_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (status_b3 && !start_valid && erase_done) |=> (!status_b3 && sel_map == '0));

  assert_chip_direct_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!status_b3 && sel_map == '0 && cmd_valid && cmd_op == 2'd2)
      |=> (start_valid && start_chip && (&sel_map)));

  assert_sector_open_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!status_b3 && cmd_valid && cmd_op == 2'd1) |=> !status_b3);
endmodule

bind erase_window_ctrl erw_checker #(.NSECT(NSECT)) u_erw_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_valid   (cmd_valid),
  .cmd_op      (cmd_op),
  .erase_done  (erase_done),
  .start_ready (start_ready),
  .status_b3   (status_b3),
  .cmd_drop    (cmd_drop),
  .sel_map     (sel_map),
  .start_valid (start_valid),
  .start_chip  (start_chip)
);

// File: tb/test_erase_window_ctrl.sv
module test_erase_window_ctrl;
  localparam int NSECT  = 8;
  localparam int WIN_US = 5;
  localparam int SECT_W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic us_tick = 1'b0, cmd_valid = 1'b0, erase_done = 1'b0, start_ready = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [SECT_W-1:0] cmd_sector = '0;
  logic status_b3, cmd_drop, start_valid, start_chip;
  logic [NSECT-1:0] sel_map;

  int checks = 0;
  int errors = 0;
  logic [NSECT:0] exp_q[$];

  always #10 clk = ~clk;

  erase_window_ctrl #(.NSECT(NSECT), .WIN_US(WIN_US)) i_erase_window_ctrl (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_sector(cmd_sector), .erase_done(erase_done),
    .start_ready(start_ready), .status_b3(status_b3), .cmd_drop(cmd_drop),
    .sel_map(sel_map), .start_valid(start_valid), .start_chip(start_chip)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [1:0] op, input logic [SECT_W-1:0] sec, input logic with_tick);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_sector = sec; us_tick = with_tick;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'd0; us_tick = 1'b0;
  endtask

  task automatic cmd_drop_chk(input logic [1:0] op, input logic exp_drop, input string req);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_sector = 3'd5;
    #2 chk(req, cmd_drop, exp_drop);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'd0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); us_tick = 1'b1;
      @(negedge clk); us_tick = 1'b0;
    end
  endtask

  task automatic handshake();
    @(negedge clk); start_ready = 1'b1;
    @(negedge clk); start_ready = 1'b0;
  endtask

  task automatic finish_erase();
    @(negedge clk); erase_done = 1'b1;
    @(negedge clk); erase_done = 1'b0;
  endtask

  // monitor: scoreboard pop on each accepted start request
  initial begin
    forever begin
      @(negedge clk); #5;
      if (rst_n && start_valid && start_ready) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R6 actual=%0h expected=none", {start_chip, sel_map});
        end else begin
          logic [NSECT:0] e;
          e = exp_q.pop_front();
          if ({start_chip, sel_map} !== e) begin
            errors++;
            $display("FAIL R5/R9 start data actual=%0h expected=%0h", {start_chip, sel_map}, e);
          end
        end
      end
    end
  end

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 status", status_b3, 0);
    chk("R1 map", sel_map, 0);
    chk("R1 valid", start_valid, 0);
    chk("R1 drop", cmd_drop, 0);
    rst_n = 1'b1;

    // R11: ticks while idle do nothing
    ticks(8);
    chk("R11 idle ticks map", sel_map, 0);
    chk("R11 idle ticks status", status_b3, 0);

    // single sector
    exp_q.push_back({1'b0, 8'h04});
    cmd(2'd1, 3'd2, 1'b0);
    chk("R2 map", sel_map, 8'h04);
    chk("R2 status", status_b3, 0);
    ticks(WIN_US - 1);
    chk("R4 no early start", start_valid, 0);
    ticks(1);
    chk("R5 start valid", start_valid, 1);
    chk("R5 status", status_b3, 1);
    chk("R5 chip flag", start_chip, 0);
    repeat (3) @(negedge clk);
    chk("R6 held valid", start_valid, 1);
    chk("R6 held map", sel_map, 8'h04);
    cmd_drop_chk(2'd1, 1'b1, "R7 sector dropped");
    chk("R7 map unchanged", sel_map, 8'h04);
    cmd_drop_chk(2'd0, 1'b1, "R7 other dropped");
    cmd_drop_chk(2'd3, 1'b0, "R8 suspend passes");
    finish_erase();
    chk("R10 done ignored before take", status_b3, 1);
    chk("R10 valid kept", start_valid, 1);
    handshake();
    chk("R6 taken", start_valid, 0);
    chk("R6 still locked", status_b3, 1);
    cmd_drop_chk(2'd2, 1'b1, "R7 chip dropped busy");
    ticks(WIN_US + 2);
    chk("R7 busy stays", status_b3, 1);
    finish_erase();
    chk("R10 status cleared", status_b3, 0);
    chk("R10 map cleared", sel_map, 0);

    // accumulate, reloads, and a reload on the final tick
    exp_q.push_back({1'b0, 8'h89});
    cmd(2'd1, 3'd0, 1'b0);
    ticks(2);
    cmd(2'd1, 3'd7, 1'b0);
    chk("R3 map", sel_map, 8'h81);
    chk("R3 status", status_b3, 0);
    ticks(WIN_US - 1);
    chk("R4 reload no start", start_valid, 0);
    cmd(2'd1, 3'd3, 1'b1);
    chk("R4 final-tick reload", start_valid, 0);
    chk("R3 map three", sel_map, 8'h89);
    ticks(WIN_US - 1);
    cmd(2'd0, 3'd1, 1'b0);
    cmd(2'd2, 3'd1, 1'b0);
    chk("R11 window ignores others map", sel_map, 8'h89);
    chk("R11 window ignores others status", start_valid, 0);
    ticks(1);
    chk("R4 start after reload", start_valid, 1);
    handshake();
    finish_erase();
    chk("R10 second clear", sel_map, 0);

    // chip erase
    exp_q.push_back({1'b1, 8'hFF});
    cmd(2'd2, 3'd0, 1'b0);
    chk("R9 valid", start_valid, 1);
    chk("R9 chip", start_chip, 1);
    chk("R9 map", sel_map, 8'hFF);
    chk("R9 status", status_b3, 1);
    handshake();
    finish_erase();
    chk("R10 chip done", status_b3, 0);

    repeat (2) @(negedge clk);
    chk("R6 scoreboard empty", exp_q.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule